// File: doc/BRIEF.md
# Atomic Masked GPIO Output Port

This block is a memory-mapped output port for a soft-core processor whose native word is `DATA_W` bits (32 by default). A single N-bit output latch drives the pins. Software reaches it through several write views, and each view changes any chosen group of pins in one bus write. Every pin that a write touches switches on the same clock edge, so a parallel bus or a group of control lines driven from the port never passes through a half-updated state.

The views are a full-width data register, a half-width set/reset register in which a set bit overrides a clear bit, separate full-width raise and lower registers, and a mask/value register. The mask/value register acts on one half of the port. A separate half-select register chooses which half. The bus is a plain synchronous interface with an address, a write strobe, write data and a combinational read path. Addresses are byte offsets.

Top module: `atomic_gpo_port`

## Requirements
- R1: After a synchronous active-low reset, every output pin is 0 and the half-select bit is 0 (lower half), so a read of offset 0x14 returns 0.
- R2: A write to offset 0x0 loads all N pins from the write data on the next rising clock edge. A read of offset 0x0 returns the current pin latch.
- R3: A write to offset 0x4 drives lower pin i high when data bit i is 1 and low when data bit N/2+i is 1, for i below N/2. When both bits are 1 the pin goes high. The upper N/2 pins are left unchanged.
- R4: A write to offset 0x8 drives high every pin whose data bit is 1. Pins whose data bit is 0 keep their value.
- R5: A write to offset 0xC drives low every pin whose data bit is 1. Pins whose data bit is 0 keep their value.
- R6: A write to offset 0x10 treats data bits [N-1:N/2] as a mask and bits [N/2-1:0] as values. Inside the selected half, pin j takes value bit j where mask bit j is 1 and keeps its value where mask bit j is 0. The other half is unchanged.
- R7: Bit 0 of a write to offset 0x14 selects the half that R6 acts on (0 = pins [N/2-1:0], 1 = pins [N-1:N/2]). A read of this offset returns that bit in bit 0 and zeros above it. Writing this register leaves the pins unchanged.
- R8: Reads of offsets 0x4, 0x8, 0xC, 0x10 and of any unmapped offset return 0. Writes to unmapped offsets leave the pins and the half-select unchanged.
- R9: While the write strobe is low, the pins hold their value whatever the address and data inputs carry.
- R10: All pins affected by a write change together on the first rising edge after the strobe. Before that edge no pin has changed, and after it none is still pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| gpio_out | output | DATA_W | Output pin latch |

## Verification
The bench builds the port with `DATA_W = 32` and `ADDR_W = 5`. The 32-bit width gives two 16-bit halves, so data patterns whose halves differ show any write that spills across the half boundary in either direction. The 5-bit address leaves offsets 0x18 to 0x1F unmapped inside the decoded range. Writes and reads there test that unknown offsets are ignored without any aliasing onto mapped registers.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

    // Register byte offsets
    localparam int unsigned OFS_DATA    = 'h00;
    localparam int unsigned OFS_SETRST  = 'h04;
    localparam int unsigned OFS_SET     = 'h08;
    localparam int unsigned OFS_CLR     = 'h0C;
    localparam int unsigned OFS_MASKVAL = 'h10;
    localparam int unsigned OFS_HALF    = 'h14;

    // One strobe per write view; at most one is high in any cycle
    typedef struct packed {
        logic data;
        logic setrst;
        logic set;
        logic clr;
        logic maskval;
        logic half;
    } wr_stb_t;

endpackage

// File: rtl/gpo_decode.sv
module gpo_decode
    import gpo_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output wr_stb_t           wr_stb,
    output logic              rd_data_sel,
    output logic              rd_half_sel
);

    wr_stb_t hit;

    always_comb begin
        hit         = '0;
        hit.data    = (addr == ADDR_W'(OFS_DATA));
        hit.setrst  = (addr == ADDR_W'(OFS_SETRST));
        hit.set     = (addr == ADDR_W'(OFS_SET));
        hit.clr     = (addr == ADDR_W'(OFS_CLR));
        hit.maskval = (addr == ADDR_W'(OFS_MASKVAL));
        hit.half    = (addr == ADDR_W'(OFS_HALF));
    end

    assign wr_stb      = wr ? hit : '0;
    assign rd_data_sel = hit.data;
    assign rd_half_sel = hit.half;

endmodule

// File: rtl/gpo_update.sv
module gpo_update
    import gpo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  wr_stb_t           wr_stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic              half_sel,
    output logic [DATA_W-1:0] set_bits,
    output logic [DATA_W-1:0] clr_bits
);

    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        set_bits = '0;
        clr_bits = '0;
        if (wr_stb.data) begin
            set_bits = wdata;
            clr_bits = ~wdata;
        end
        if (wr_stb.set) begin
            set_bits = wdata;
        end
        if (wr_stb.clr) begin
            clr_bits = wdata;
        end
        if (wr_stb.setrst) begin
            for (int i = 0; i < HALF_W; i++) begin
                set_bits[i] = wdata[i];
                // raise overrides lower for the same pin
                clr_bits[i] = wdata[HALF_W+i] & ~wdata[i];
            end
        end
        if (wr_stb.maskval) begin
            for (int i = 0; i < HALF_W; i++) begin
                if (half_sel) begin
                    set_bits[HALF_W+i] = wdata[HALF_W+i] &  wdata[i];
                    clr_bits[HALF_W+i] = wdata[HALF_W+i] & ~wdata[i];
                end else begin
                    set_bits[i] = wdata[HALF_W+i] &  wdata[i];
                    clr_bits[i] = wdata[HALF_W+i] & ~wdata[i];
                end
            end
        end
    end

endmodule

// File: rtl/gpo_readback.sv
module gpo_readback #(
    parameter int DATA_W = 32
) (
    input  logic              sel_data,
    input  logic              sel_half,
    input  logic [DATA_W-1:0] pins,
    input  logic              half_sel,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (sel_data) begin
            rdata = pins;
        end else if (sel_half) begin
            rdata[0] = half_sel;
        end
    end

endmodule

// File: rtl/atomic_gpo_port.sv
module atomic_gpo_port
    import gpo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] gpio_out
);

    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] pins;
        logic              half;
    } port_state_t;

    port_state_t st_d, st_q;

    wr_stb_t           wr_stb;
    logic              rd_data_sel;
    logic              rd_half_sel;
    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;

    gpo_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr        (bus_addr),
        .wr          (bus_wr),
        .wr_stb      (wr_stb),
        .rd_data_sel (rd_data_sel),
        .rd_half_sel (rd_half_sel)
    );

    gpo_update #(.DATA_W(DATA_W)) u_update (
        .wr_stb   (wr_stb),
        .wdata    (bus_wdata),
        .half_sel (st_q.half),
        .set_bits (set_bits),
        .clr_bits (clr_bits)
    );

    gpo_readback #(.DATA_W(DATA_W)) u_readback (
        .sel_data (rd_data_sel),
        .sel_half (rd_half_sel),
        .pins     (st_q.pins),
        .half_sel (st_q.half),
        .rdata    (bus_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pins = (st_q.pins & ~clr_bits) | set_bits;
        if (wr_stb.half) begin
            st_d.half = bus_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gpio_out = st_q.pins;

    // ---------------- assertions ----------------
    logic addr_unmapped;
    assign addr_unmapped = (bus_addr[1:0] != 2'b00) || (int'(bus_addr) > int'(OFS_HALF));

    assert_one_view_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));

    assert_data_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_DATA)) |=> gpio_out == $past(bus_wdata));

    assert_setrst_upper_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_SETRST))
        |=> gpio_out[DATA_W-1:HALF_W] == $past(gpio_out[DATA_W-1:HALF_W]));

    assert_setrst_raise_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_SETRST))
        |=> (gpio_out[HALF_W-1:0] & $past(bus_wdata[HALF_W-1:0])) == $past(bus_wdata[HALF_W-1:0]));

    assert_set_only_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_SET))
        |=> ((gpio_out & $past(bus_wdata)) == $past(bus_wdata))
         && ((gpio_out & ~$past(bus_wdata)) == ($past(gpio_out) & ~$past(bus_wdata))));

    assert_clr_only_lowers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CLR))
        |=> ((gpio_out & $past(bus_wdata)) == '0)
         && ((gpio_out & ~$past(bus_wdata)) == ($past(gpio_out) & ~$past(bus_wdata))));

    assert_half_write_keeps_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_HALF)) |=> $stable(gpio_out));

    assert_unmapped_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && addr_unmapped) |=> $stable(gpio_out));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(gpio_out));

endmodule

// File: tb/atomic_gpo_port_bench.sv
module atomic_gpo_port_bench;

    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] gpio_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk; // 125 MHz

    atomic_gpo_port #(.DATA_W(DW), .ADDR_W(AW)) u_atomic_gpo_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gpio_out  (gpio_out)
    );

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] pins;
        logic [7:0]    req;
    } vec_t;

    // cumulative: each expected value assumes all earlier rows were applied
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{5'h00, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 8'd2},
        '{5'h08, 32'h0000_00F0, 32'hA5A5_5AFA, 8'd4},
        '{5'h0C, 32'hA000_0000, 32'h05A5_5AFA, 8'd5},
        '{5'h04, 32'h00FF_0003, 32'h05A5_5A03, 8'd3},
        '{5'h04, 32'hFFFF_0000, 32'h05A5_0000, 8'd3},
        '{5'h10, 32'h00FF_0055, 32'h05A5_0055, 8'd6},
        '{5'h14, 32'h0000_0001, 32'h05A5_0055, 8'd7},
        '{5'h10, 32'hF00F_1234, 32'h15A4_0055, 8'd6},
        '{5'h18, 32'hFFFF_FFFF, 32'h15A4_0055, 8'd8},
        '{5'h00, 32'h0000_0000, 32'h0000_0000, 8'd2},
        '{5'h08, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd4},
        '{5'h10, 32'hFFFF_0000, 32'h0000_FFFF, 8'd6}
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, strobe caught at next posedge, results visible at following negedge
    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 pins after reset", gpio_out, '0);
        bus_read(5'h14, rd);
        check("R1 half-select after reset", rd, '0);

        // vector table
        for (int k = 0; k < NV; k++) begin
            bus_write(VECS[k].addr, VECS[k].wdata);
            check($sformatf("R%0d vector %0d pins", VECS[k].req, k), gpio_out, VECS[k].pins);
            bus_read(5'h00, rd);
            check($sformatf("R2 vector %0d readback", k), rd, VECS[k].pins);
        end

        // R7 half-select readback (row 6 set it to 1)
        bus_read(5'h14, rd);
        check("R7 half-select reads 1", rd, 32'h0000_0001);

        // R8 write-only and unmapped offsets read zero
        for (int a = 4; a < 32; a += 4) begin
            if (a != 'h14) begin
                bus_read(AW'(a), rd);
                check($sformatf("R8 read of %0h is zero", a), rd, '0);
            end
        end
        bus_read(5'h01, rd);
        check("R8 misaligned read is zero", rd, '0);
        // R8 unmapped write must not touch half-select
        bus_write(5'h1C, 32'h0000_0000);
        bus_read(5'h14, rd);
        check("R8 unmapped write keeps half-select", rd, 32'h0000_0001);

        // R9 strobe low: data on bus ignored
        @(negedge clk);
        bus_addr  = 5'h00;
        bus_wdata = 32'h1234_5678;
        bus_wr    = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 idle write data ignored", gpio_out, 32'h0000_FFFF);

        // R10 all pins switch on one edge, not before
        @(negedge clk);
        bus_addr  = 5'h00;
        bus_wdata = 32'hFFFF_0000;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        check("R10 all pins switched after first edge", gpio_out, 32'hFFFF_0000);
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        check("R10 no pin pending a cycle later", gpio_out, 32'hFFFF_0000);

        // R6 lower half after reselecting lower
        bus_write(5'h14, 32'hFFFF_FFFE);
        check("R7 half write keeps pins", gpio_out, 32'hFFFF_0000);
        bus_write(5'h10, 32'h8001_8000);
        check("R6 lower half masked write", gpio_out, 32'hFFFF_8000);

        // R3 set wins over clear on all lower pins
        bus_write(5'h04, 32'hFFFF_FFFF);
        check("R3 raise wins on every lower pin", gpio_out, 32'hFFFF_FFFF);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 pins after second reset", gpio_out, '0);
        bus_read(5'h14, rd);
        check("R1 half-select after second reset", rd, '0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule